// File: doc/BRIEF.md
# SMBus Register Access Bridge

This block sits between an SMBus slave byte engine and an on-chip register bus. The byte engine writes and reads a small staging file: a command byte, a byte count, four address bytes, four data bytes and a read-only status byte. Writes to any staging byte other than the command byte only load that byte. A write to the command byte checks the request and, if it is consistent, starts exactly one internal transaction. That transaction goes either to function configuration space or to a memory-mapped register window.

While the transaction is outstanding, the bridge asks the byte engine to stretch the clock. Every byte write that arrives during that time is answered with NAK and leaves the staging file untouched. When the response returns, read data lands in the data bytes and the status byte records completion and any error. The byte engine can then read them back.

Top module: `smb_reg_bridge`

## Requirements
- R1: An internal request (`bus_valid` rising) is started only by an accepted write to staging index 0, the command byte. Writes to indices 1 to 9 only load their byte and start nothing.
- R2: Command byte encoding is as follows. Bit 0 is the direction (1 = write, 0 = read). Bit 1 is the space (1 = memory window, 0 = configuration, shown on `bus_cfg`). Bits [4:2] give the data byte count N.
- R3: A byte write received while a command is in progress is answered with NAK (`ack_nak` = 1 in the `ack_valid` cycle) and changes no staging byte.
- R4: `stretch` is high from the cycle after an accepted command until the cycle after the internal response, and it is high whenever `bus_valid` is high.
- R5: For configuration space, `bus_addr` = {17'b0, index4[2:0], index3[3:0], index2}. Here index4 is the third address byte, index3 is the extended register nibble and index2 is the register offset. Index 5 and the other address bits are ignored.
- R6: For memory space, `bus_addr` = {13'b0, index4[2:0], index3, index2}, which is a 19-bit offset. Index 5 is ignored.
- R7: Data is little-endian. Indices 6, 7, 8 and 9 hold bits [7:0], [15:8], [23:16] and [31:24]. Write data is sent from them, and read data is latched into them when the response has no error.
- R8: The status byte at index 10 reads {6'b0, err, done}. Both bits clear when a command is accepted. When the response arrives, done is set and err takes `rsp_err`.
- R9: A command with N = 0, N > 4, or N different from the byte count register at index 1 makes no internal request and no stretch, and sets status to done = 1, err = 1 in the next cycle.
- R10: `bus_strb` enables the low N bytes for writes (1 = 0001, 2 = 0011, 3 = 0111, 4 = 1111) and is 0000 for reads.
- R11: A request keeps `bus_valid`, address, data and direction stable until `bus_ready` is high.
- R12: A byte write received while idle is answered with ACK (`ack_valid` = 1, `ack_nak` = 0) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe from the SMBus engine |
| wr_reg | input | 4 | Staging index written |
| wr_data | input | 8 | Byte written |
| ack_valid | output | 1 | Write response valid, one cycle after `wr_en` |
| ack_nak | output | 1 | 1 = NAK, 0 = ACK |
| rd_reg | input | 4 | Staging index read |
| rd_data | output | 8 | Byte at `rd_reg` |
| stretch | output | 1 | Clock-stretch request |
| bus_valid | output | 1 | Internal request valid |
| bus_ready | input | 1 | Internal request accepted |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_cfg | output | 1 | 1 = configuration space, 0 = memory window |
| bus_addr | output | 32 | Internal address |
| bus_wdata | output | 32 | Write data |
| bus_strb | output | 4 | Byte enables |
| rsp_valid | input | 1 | Internal response valid |
| rsp_rdata | input | 32 | Read data |
| rsp_err | input | 1 | Response error |

## Verification
Several properties are checked on every cycle: NAK during a pending command, ACK when idle, a request starting only after a command write, stretch covering every request and dropping after the response, the address bounds for each space, the strobe shapes, and request stability until ready. Other behaviours need the bench's scenarios. These are the exact address built from the bytes, the byte order of write and read data, that refused writes leave the staging bytes unchanged, the status byte values, and that count mismatches produce no request at all.

// File: rtl/smb_reg_bridge.sv
module smb_reg_bridge (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_reg,
  input  logic [7:0]  wr_data,
  output logic        ack_valid,
  output logic        ack_nak,
  input  logic [3:0]  rd_reg,
  output logic [7:0]  rd_data,
  output logic        stretch,
  output logic        bus_valid,
  input  logic        bus_ready,
  output logic        bus_write,
  output logic        bus_cfg,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic [3:0]  bus_strb,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_rdata,
  input  logic        rsp_err
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t        st;
  logic [7:0] cmd_q, cnt_q, ab0, ab1, ab2, ab3;
  logic [31:0] data_q;
  logic       done_q, err_q;
  logic [3:0] strb_m;

  wire       busy   = (st != S_IDLE);
  wire       take   = wr_en && !busy;
  wire [2:0] nb     = wr_data[4:2];
  wire       cmd_ok = (cnt_q == {5'd0, nb}) && (nb != 3'd0) && (nb <= 3'd4);

  assign stretch   = busy;
  assign bus_valid = (st == S_REQ);
  assign bus_write = cmd_q[0];
  assign bus_cfg   = !cmd_q[1];
  assign bus_wdata = data_q;
  assign bus_addr  = cmd_q[1] ? {13'd0, ab2[2:0], ab1, ab0}
                              : {17'd0, ab2[2:0], ab1[3:0], ab0};

  always_comb begin
    case (cmd_q[4:2])
      3'd1:    strb_m = 4'b0001;
      3'd2:    strb_m = 4'b0011;
      3'd3:    strb_m = 4'b0111;
      3'd4:    strb_m = 4'b1111;
      default: strb_m = 4'b0000;
    endcase
  end
  assign bus_strb = cmd_q[0] ? strb_m : 4'b0000;

  always_comb begin
    case (rd_reg)
      4'd0:    rd_data = cmd_q;
      4'd1:    rd_data = cnt_q;
      4'd2:    rd_data = ab0;
      4'd3:    rd_data = ab1;
      4'd4:    rd_data = ab2;
      4'd5:    rd_data = ab3;
      4'd6:    rd_data = data_q[7:0];
      4'd7:    rd_data = data_q[15:8];
      4'd8:    rd_data = data_q[23:16];
      4'd9:    rd_data = data_q[31:24];
      4'd10:   rd_data = {6'd0, err_q, done_q};
      default: rd_data = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      cnt_q     <= '0;
      ab0       <= '0;
      ab1       <= '0;
      ab2       <= '0;
      ab3       <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ack_valid <= 1'b0;
      ack_nak   <= 1'b0;
    end else begin
      ack_valid <= wr_en;
      ack_nak   <= wr_en && busy;
      if (take) begin
        case (wr_reg)
          4'd0: begin
            cmd_q <= wr_data;
            if (cmd_ok) begin
              st     <= S_REQ;
              done_q <= 1'b0;
              err_q  <= 1'b0;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
          4'd1:    cnt_q <= wr_data;
          4'd2:    ab0 <= wr_data;
          4'd3:    ab1 <= wr_data;
          4'd4:    ab2 <= wr_data;
          4'd5:    ab3 <= wr_data;
          4'd6:    data_q[7:0]   <= wr_data;
          4'd7:    data_q[15:8]  <= wr_data;
          4'd8:    data_q[23:16] <= wr_data;
          4'd9:    data_q[31:24] <= wr_data;
          default: ;
        endcase
      end
      case (st)
        S_REQ:  if (bus_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          err_q  <= rsp_err;
          if (!cmd_q[0] && !rsp_err) data_q <= rsp_rdata;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_reg_bridge_chk.sv
module smb_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_reg,
  input logic        ack_valid,
  input logic        ack_nak,
  input logic        stretch,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_write,
  input logic        bus_cfg,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_strb,
  input logic        rsp_valid
);
  AST_NAK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_en && stretch |=> ack_valid && ack_nak); // R3
  AST_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) wr_en && !stretch |=> ack_valid && !ack_nak); // R12
  AST_START_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_valid) |-> $past(wr_en && wr_reg == 4'd0)); // R1
  AST_STRETCH_COVERS: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> stretch); // R4
  AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stretch && !bus_valid && rsp_valid |=> !stretch); // R4
  AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && bus_cfg |-> bus_addr[31:15] == 17'd0); // R5
  AST_MEM_RANGE: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && !bus_cfg |-> bus_addr[31:19] == 13'd0); // R6
  AST_READ_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && !bus_write |-> bus_strb == 4'b0000); // R10
  AST_WRITE_STRB: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && bus_write |-> bus_strb inside {4'b0001, 4'b0011, 4'b0111, 4'b1111}); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)); // R11
endmodule

bind smb_reg_bridge smb_reg_bridge_chk u_chk (.*);

// File: tb/smb_reg_bridge_test.sv
`timescale 1ns/1ps
module smb_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_reg = '0;
  logic [7:0]  wr_data = '0;
  logic        ack_valid, ack_nak;
  logic [3:0]  rd_reg = '0;
  logic [7:0]  rd_data;
  logic        stretch, bus_valid, bus_write, bus_cfg;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_strb;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        rsp_err = 1'b0;

  int checks = 0;
  int fails = 0;
  int ready_dly = 0;
  int rsp_dly = 1;
  logic [31:0] t_rdata = '0;
  logic        t_err = 1'b0;

  typedef struct packed {
    logic        w;
    logic        cfg;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
  } req_t;
  req_t exp_q[$];

  always #2.5 clk = ~clk;

  smb_reg_bridge uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sm_wr(input logic [3:0] r, input logic [7:0] v, input bit exp_nak, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = r; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    chk(ack_valid && ack_nak == exp_nak, req, {30'd0, ack_valid, ack_nak}, {30'd0, 1'b1, exp_nak});
  endtask

  task automatic rd_chk(input logic [3:0] r, input logic [7:0] exp, input string req);
    rd_reg = r;
    #1;
    chk(rd_data == exp, req, {24'd0, rd_data}, {24'd0, exp});
  endtask

  task automatic wait_idle();
    int n = 0;
    while (stretch && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(!stretch, "R4 stretch release", {31'd0, stretch}, 32'd0);
  endtask

  task automatic push(input logic w, input logic cfg, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    req_t it;
    it.w = w; it.cfg = cfg; it.addr = a; it.wdata = d; it.strb = s;
    exp_q.push_back(it);
  endtask

  task automatic load(input logic [7:0] c, input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                      input logic [7:0] a3, input logic [31:0] d);
    sm_wr(4'd1, c, 1'b0, "R12 ack cnt");
    sm_wr(4'd2, a0, 1'b0, "R12 ack a0");
    sm_wr(4'd3, a1, 1'b0, "R12 ack a1");
    sm_wr(4'd4, a2, 1'b0, "R12 ack a2");
    sm_wr(4'd5, a3, 1'b0, "R12 ack a3");
    sm_wr(4'd6, d[7:0], 1'b0, "R12 ack d0");
    sm_wr(4'd7, d[15:8], 1'b0, "R12 ack d1");
    sm_wr(4'd8, d[23:16], 1'b0, "R12 ack d2");
    sm_wr(4'd9, d[31:24], 1'b0, "R12 ack d3");
  endtask

  // Target model
  initial begin
    forever begin
      @(negedge clk);
      if (bus_valid) begin
        repeat (ready_dly) @(negedge clk);
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        repeat (rsp_dly) @(negedge clk);
        rsp_valid = 1'b1; rsp_rdata = t_rdata; rsp_err = t_err;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  // Monitor: compares each new request against the scoreboard
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (rst_n && bus_valid && !prev_v) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected request", bus_addr, 32'd0);
      end else begin
        req_t e;
        e = exp_q.pop_front();
        chk(bus_write == e.w, "R2 direction", {31'd0, bus_write}, {31'd0, e.w});
        chk(bus_cfg == e.cfg, "R2 space", {31'd0, bus_cfg}, {31'd0, e.cfg});
        chk(bus_addr == e.addr, e.cfg ? "R5 cfg address" : "R6 mem address", bus_addr, e.addr);
        if (e.w) chk(bus_wdata == e.wdata, "R7 write data order", bus_wdata, e.wdata);
        chk(bus_strb == e.strb, "R10 strobe", {28'd0, bus_strb}, {28'd0, e.strb});
      end
    end
    prev_v = bus_valid;
  end

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stretch && !bus_valid && !ack_valid, "R4 reset state", {29'd0, stretch, bus_valid, ack_valid}, 32'd0);
    rd_chk(4'd10, 8'h00, "R8 reset status");

    // Configuration write, 4 bytes (R1 R2 R5 R7 R10)
    load(8'd4, 8'h34, 8'hF5, 8'hFB, 8'h77, 32'h44332211);
    chk(!stretch, "R1 no start on staging writes", {31'd0, stretch}, 32'd0);
    push(1'b1, 1'b1, 32'h0000_3534, 32'h44332211, 4'b1111);
    sm_wr(4'd0, 8'h11, 1'b0, "R12 ack cmd");
    chk(stretch, "R4 stretch after cmd", {31'd0, stretch}, 32'd1);
    rd_chk(4'd10, 8'h00, "R8 status cleared on accept");
    wait_idle();
    rd_chk(4'd10, 8'h01, "R8 done after write");

    // Memory read, 2 bytes, slow target (R3 R6 R7 R8)
    ready_dly = 4; rsp_dly = 3; t_rdata = 32'hCAFEF00D; t_err = 1'b0;
    load(8'd2, 8'hC0, 8'hDE, 8'hAD, 8'hFF, 32'h0);
    push(1'b0, 1'b0, 32'h0005_DEC0, 32'h0, 4'b0000);
    sm_wr(4'd0, 8'h0A, 1'b0, "R12 ack cmd read");
    sm_wr(4'd1, 8'h03, 1'b1, "R3 nak cnt while busy");
    sm_wr(4'd6, 8'h99, 1'b1, "R3 nak data while busy");
    sm_wr(4'd0, 8'h11, 1'b1, "R3 nak cmd while busy");
    chk(stretch, "R4 stretch held", {31'd0, stretch}, 32'd1);
    wait_idle();
    rd_chk(4'd1, 8'h02, "R3 cnt unchanged");
    rd_chk(4'd10, 8'h01, "R8 done after read");
    rd_chk(4'd6, 8'h0D, "R7 read byte0");
    rd_chk(4'd7, 8'hF0, "R7 read byte1");
    rd_chk(4'd8, 8'hFE, "R7 read byte2");
    rd_chk(4'd9, 8'hCA, "R7 read byte3");

    // Memory write, 1 byte (R10)
    ready_dly = 0; rsp_dly = 0;
    sm_wr(4'd1, 8'd1, 1'b0, "R12 ack cnt1");
    push(1'b1, 1'b0, 32'h0005_DEC0, 32'hCAFEF00D, 4'b0001);
    sm_wr(4'd0, 8'h07, 1'b0, "R12 ack cmd w1");
    wait_idle();

    // Count mismatch and zero count (R9)
    sm_wr(4'd1, 8'd3, 1'b0, "R12 ack cnt3");
    sm_wr(4'd0, 8'h11, 1'b0, "R9 ack mismatched cmd");
    chk(!stretch && !bus_valid, "R9 no access on mismatch", {30'd0, stretch, bus_valid}, 32'd0);
    rd_chk(4'd10, 8'h03, "R9 error status");
    sm_wr(4'd1, 8'd0, 1'b0, "R12 ack cnt0");
    sm_wr(4'd0, 8'h01, 1'b0, "R9 ack zero cmd");
    chk(!stretch && !bus_valid, "R9 no access on zero count", {30'd0, stretch, bus_valid}, 32'd0);
    rd_chk(4'd10, 8'h03, "R9 error status zero");

    // Configuration read with error response (R5 R7 R8)
    t_rdata = 32'h01020304; t_err = 1'b1; rsp_dly = 2;
    sm_wr(4'd1, 8'd4, 1'b0, "R12 ack cnt4");
    sm_wr(4'd4, 8'h0A, 1'b0, "R12 ack a2 fn2");
    sm_wr(4'd3, 8'h3C, 1'b0, "R12 ack a1 ext");
    push(1'b0, 1'b1, 32'h0000_2CC0, 32'h0, 4'b0000);
    sm_wr(4'd0, 8'h10, 1'b0, "R12 ack cfg read");
    wait_idle();
    rd_chk(4'd10, 8'h03, "R8 error from response");
    rd_chk(4'd6, 8'h0D, "R7 data kept on error");

    // Configuration read, good response (R7)
    t_err = 1'b0;
    push(1'b0, 1'b1, 32'h0000_2CC0, 32'h0, 4'b0000);
    sm_wr(4'd0, 8'h10, 1'b0, "R12 ack cfg read 2");
    wait_idle();
    rd_chk(4'd6, 8'h04, "R7 cfg read byte0");
    rd_chk(4'd9, 8'h01, "R7 cfg read byte3");
    rd_chk(4'd10, 8'h01, "R8 done clean");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all requests seen", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule